// File: doc/BRIEF.md
# Vector length state update unit

This unit owns a 64-bit vector-loop status word and carries out two management commands on it, each presented for one clock cycle. The set-length command picks a new maximum vector length and a new current vector length, may change the vertical-first mode bit, and returns the resulting vector length. The step command records a pair of sub-vector pack and unpack flags and returns them.

Both lengths are 7-bit values. The maximum length comes either from the command's immediate or from the stored word. The current length comes from one of four sources in a fixed priority: the stored word, a register operand, the immediate, or a loop-counter operand. The two wide operands saturate at 127. The chosen length is then clamped so that it never exceeds the new maximum. The status word is written on the edge that accepts the command, and the 64-bit result appears one cycle later, marked by a valid strobe.

Status word layout (bit 0 is the least significant): bits 6:0 hold the maximum length, bits 13:7 the current length, bit 14 vertical-first, bit 15 persist, bit 16 pack, bit 17 unpack. All other bits are zero.

Top module: `vl_state_unit`

## Requirements
- R1: After reset the status word is all zeros and res_valid is low.
- R2: For a set-length command (cmd_op=0) with ms=1, the new maximum length is imm. With ms=0 the stored maximum length is kept.
- R3: For a set-length command with vs=0, the candidate current length is the stored current length.
- R4: For a set-length command with vs=1 and ra_idx nonzero, the candidate is ra_val, or 127 if ra_val exceeds 127.
- R5: For a set-length command with vs=1, ra_idx zero and rt_idx zero, the candidate is imm.
- R6: For a set-length command with vs=1, ra_idx zero and rt_idx nonzero, the candidate is ctr_val, or 127 if ctr_val exceeds 127.
- R7: The stored current length is the smaller of the candidate and the new maximum length, so it never exceeds the stored maximum.
- R8: One cycle after any command res_valid is high. For a set-length command res_data is the new current length, zero-extended to 64 bits.
- R9: For a set-length command with vs or ms set, vertical-first takes vf and persist is cleared. When both are clear, those two bits are kept.
- R10: For a step command (cmd_op=1) with imm[3] and imm[4] both 1, pack takes imm[5] and unpack takes imm[6]. res_data is {62 zeros, unpack, pack}. No other status bit changes.
- R11: For a step command without both imm[3] and imm[4] set, the status word is unchanged and res_data returns the stored unpack and pack bits in bits 1:0.
- R12: In a cycle without cmd_valid the status word holds its value, and res_valid is low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 1 | 0 = set length, 1 = step |
| imm | input | 7 | Immediate value and step flags |
| ra_idx | input | 5 | Register index of the length operand |
| rt_idx | input | 5 | Destination register index |
| ra_val | input | 64 | Length operand value |
| ctr_val | input | 64 | Loop-counter operand value |
| ms | input | 1 | Load maximum length from imm |
| vs | input | 1 | Choose a new current length |
| vf | input | 1 | Requested vertical-first mode |
| res_valid | output | 1 | Result valid, one cycle after a command |
| res_data | output | 64 | Command result |
| status_o | output | 64 | Current status word |

## Verification
The hardest case to reach is a saturated wide operand that is then clamped again by a smaller maximum. It needs a value above 127 in the upper operand bits, the right index combination, and a maximum that was set below 127 by an earlier command. Random stimulus draws each wide operand from separate small, boundary and full-width ranges. It also issues commands back to back, so the stored maximum keeps changing. Directed cases then fix the exact orderings: shrinking the maximum under a kept length, and ctr_val just above the saturation bound.

// File: rtl/vl_state_unit.sv
module vl_state_unit #(
  parameter int XLEN = 64,
  parameter int LW   = 7,
  parameter int IDXW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic            cmd_op,
  input  logic [LW-1:0]   imm,
  input  logic [IDXW-1:0] ra_idx,
  input  logic [IDXW-1:0] rt_idx,
  input  logic [XLEN-1:0] ra_val,
  input  logic [XLEN-1:0] ctr_val,
  input  logic            ms,
  input  logic            vs,
  input  logic            vf,
  output logic            res_valid,
  output logic [XLEN-1:0] res_data,
  output logic [XLEN-1:0] status_o
);
  localparam int MVL_LO = 0;
  localparam int VL_LO  = MVL_LO + LW;
  localparam int VF_B   = VL_LO + LW;
  localparam int PER_B  = VF_B + 1;
  localparam int PK_B   = PER_B + 1;
  localparam int UP_B   = PK_B + 1;
  localparam logic [XLEN-1:0] LMAX = XLEN'((64'd1 << LW) - 1);

  logic [XLEN-1:0] st_q, st_d, res_d;
  logic [LW-1:0]   mvl_cur, vl_cur, mvl_nxt, vl_raw, vl_nxt;
  logic            step_en;

  assign mvl_cur = st_q[MVL_LO +: LW];
  assign vl_cur  = st_q[VL_LO +: LW];
  assign mvl_nxt = ms ? imm : mvl_cur;
  assign vl_nxt  = (vl_raw > mvl_nxt) ? mvl_nxt : vl_raw;
  assign step_en = imm[3] & imm[4];

  always_comb begin
    if (!vs)
      vl_raw = vl_cur;
    else if (ra_idx != '0)
      vl_raw = (ra_val > LMAX) ? LMAX[LW-1:0] : ra_val[LW-1:0];
    else if (rt_idx == '0)
      vl_raw = imm;
    else
      vl_raw = (ctr_val > LMAX) ? LMAX[LW-1:0] : ctr_val[LW-1:0];
  end

  always_comb begin
    st_d  = st_q;
    res_d = '0;
    if (cmd_op == 1'b0) begin
      st_d[MVL_LO +: LW] = mvl_nxt;
      st_d[VL_LO +: LW]  = vl_nxt;
      if (vs | ms) begin
        st_d[VF_B]  = vf;
        st_d[PER_B] = 1'b0;
      end
      res_d[LW-1:0] = vl_nxt;
    end else begin
      if (step_en) begin
        st_d[PK_B] = imm[5];
        st_d[UP_B] = imm[6];
      end
      res_d[1:0] = {st_d[UP_B], st_d[PK_B]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= cmd_valid;
      if (cmd_valid) begin
        st_q     <= st_d;
        res_data <= res_d;
      end
    end
  end

  assign status_o = st_q;
endmodule

// File: rtl/vl_state_unit_chk.sv
module vl_state_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_op,
  input logic        res_valid,
  input logic [63:0] res_data,
  input logic [63:0] status_o
);
  assert_vl_le_mvl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[13:7] <= status_o[6:0]);

  assert_res_follows_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> res_valid);

  assert_setlen_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_op) |=> (res_data == {57'd0, status_o[13:7]}));

  assert_step_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op) |=> (res_data == {62'd0, status_o[17:16]}));

  assert_step_keeps_lengths_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op) |=> $stable(status_o[15:0]));

  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> ($stable(status_o) && !res_valid));

  assert_unused_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[63:18] == '0);
endmodule

bind vl_state_unit vl_state_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .res_valid(res_valid), .res_data(res_data), .status_o(status_o)
);

// File: tb/vl_state_unit_tb.sv
module vl_state_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_op = 1'b0, ms = 1'b0, vs = 1'b0, vf = 1'b0;
  logic [6:0]  imm = '0;
  logic [4:0]  ra_idx = '0, rt_idx = '0;
  logic [63:0] ra_val = '0, ctr_val = '0;
  logic        res_valid;
  logic [63:0] res_data, status_o;

  int errors = 0, checks = 0;
  logic [6:0] m_mvl = '0, m_vl = '0;
  logic m_vf = 1'b0, m_per = 1'b0, m_pk = 1'b0, m_up = 1'b0;

  always #4 clk = ~clk;

  vl_state_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .imm(imm),
    .ra_idx(ra_idx), .rt_idx(rt_idx), .ra_val(ra_val), .ctr_val(ctr_val),
    .ms(ms), .vs(vs), .vf(vf), .res_valid(res_valid), .res_data(res_data),
    .status_o(status_o)
  );

  function automatic logic [6:0] sat7(input logic [63:0] v);
    return (v > 64'd127) ? 7'd127 : v[6:0];
  endfunction

  function automatic logic [63:0] exp_status();
    return {46'd0, m_up, m_pk, m_per, m_vf, m_vl, m_mvl};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input string req, input logic op, input logic [6:0] im,
                       input logic [4:0] ra, input logic [4:0] rt,
                       input logic [63:0] rv, input logic [63:0] cv,
                       input logic m, input logic v, input logic f);
    logic [6:0] nm, cand;
    logic [63:0] er;
    cmd_valid = 1'b1; cmd_op = op; imm = im; ra_idx = ra; rt_idx = rt;
    ra_val = rv; ctr_val = cv; ms = m; vs = v; vf = f;
    if (!op) begin
      nm = m ? im : m_mvl;
      if (!v) cand = m_vl;
      else if (ra != 0) cand = sat7(rv);
      else if (rt == 0) cand = im;
      else cand = sat7(cv);
      m_mvl = nm;
      m_vl = (cand > nm) ? nm : cand;
      if (m | v) begin m_vf = f; m_per = 1'b0; end
      er = {57'd0, m_vl};
    end else begin
      if (im[3] && im[4]) begin m_pk = im[5]; m_up = im[6]; end
      er = {62'd0, m_up, m_pk};
    end
    @(negedge clk);
    check({req, " valid"}, {63'd0, res_valid}, 64'd1);
    check({req, " result"}, res_data, er);
    check({req, " status"}, status_o, exp_status());
  endtask

  task automatic idle();
    cmd_valid = 1'b0;
    imm = $urandom; ms = 1'b1; vs = 1'b1; cmd_op = $urandom;
    @(negedge clk);
    check("R12 idle valid", {63'd0, res_valid}, 64'd0);
    check("R12 idle status", status_o, exp_status());
  endtask

  function automatic logic [63:0] pick_wide();
    case ($urandom_range(0, 3))
      0: return 64'($urandom_range(0, 127));
      1: return 64'($urandom_range(126, 130));
      2: return {$urandom, $urandom};
      default: return {32'd0, $urandom};
    endcase
  endfunction

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 reset status", status_o, 64'd0);
    check("R1 reset valid", {63'd0, res_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2/R5/R7: set max 10, imm-selected length clamps
    issue("R2 ms load", 0, 7'd10, 5'd0, 5'd0, 0, 0, 1, 0, 1);
    issue("R5 R7 imm clamp", 0, 7'd20, 5'd0, 5'd0, 0, 0, 0, 1, 0);
    // R4 overflow saturate with max 127
    issue("R2 max 127", 0, 7'd127, 5'd0, 5'd0, 0, 0, 1, 0, 0);
    issue("R4 ra overflow", 0, 7'd0, 5'd3, 5'd1, 64'h1_0000_0000, 0, 0, 1, 1);
    issue("R4 ra small", 0, 7'd0, 5'd3, 5'd1, 64'd55, 0, 0, 1, 0);
    // R6 counter just over bound, then exact
    issue("R6 ctr 128", 0, 7'd0, 5'd0, 5'd9, 0, 64'd128, 0, 1, 1);
    issue("R6 ctr 40", 0, 7'd0, 5'd0, 5'd9, 0, 64'd40, 0, 1, 1);
    // R3/R7: keep length while shrinking max
    issue("R3 R7 shrink", 0, 7'd5, 5'd0, 5'd0, 0, 0, 1, 0, 0);
    // R9: neither flag keeps vf
    issue("R9 keep vf", 0, 7'd99, 5'd4, 5'd4, 64'd2, 64'd2, 0, 0, 1);
    // R10/R11 step
    issue("R10 step set", 1, 7'b1111000, 0, 0, 0, 0, 0, 0, 0);
    issue("R11 step noop", 1, 7'b0010000, 0, 0, 0, 0, 0, 0, 0);
    issue("R10 step clear", 1, 7'b0111000, 0, 0, 0, 0, 0, 0, 0);
    idle();
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 7) == 0) idle();
      else issue($urandom_range(0, 3) == 0 ? "R10 R11 rand step" : "R2-R9 rand setlen",
                 $urandom_range(0, 3) == 0, 7'($urandom),
                 ($urandom_range(0, 2) == 0) ? 5'd0 : 5'($urandom),
                 ($urandom_range(0, 2) == 0) ? 5'd0 : 5'($urandom),
                 pick_wide(), pick_wide(), 1'($urandom), 1'($urandom), 1'($urandom));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule